// File: doc/BRIEF.md
# Command Output Ring Engine

This block drains a circular buffer of 32-bit command words that software keeps in host memory and hands the words, one at a time, to a downstream serial command port. Software selects the ring size (2, 16 or 256 entries, limited by a build-time capability mask), programs a 128-byte aligned base address, clears the read pointer through a two-phase handshake and then advances the write pointer to the index of the last command it has placed in the ring. While the run bit is set, the engine fetches the entry after the read pointer, presents it on a valid/ready output and advances the read pointer once the word is accepted, until the read pointer catches up with the write pointer.

Memory is read through a plain request/response port: a one-cycle request with a 64-bit byte address, answered some cycles later by a one-cycle response strobe with the data word. Only one fetch is in flight at any time, so free space for software is always (rp - wp - 1) mod N and at most N - 1 commands are pending.

Top module: `cmd_ring_engine`

## Requirements
- R1: Register 0 reads the capability mask in bits [6:4] (bit 4 = 2 entries, bit 5 = 16, bit 6 = 256) and the size select in bits [1:0] (0 = 2 entries, 1 = 16, 2 = 256); the select is 0 after reset.
- R2: A write to the size select whose encoding is 3 or whose capability bit is clear leaves the select unchanged.
- R3: While the run bit (register 5, bit 0) is set, writes to the size select (register 0) and to the base address (registers 1 and 2) are ignored.
- R4: Register 1 holds the low base word with bits [6:0] always reading 0 (128-byte alignment); register 2 holds the high base word when 64-bit addressing is built in and reads 0 otherwise.
- R5: Writing register 3 with bit 15 set makes bit 15 read 1 from the next cycle and forces the read pointer (register 3, bits [7:0]) to 0; while bit 15 stays set no fetch starts; writing bit 15 as 0 makes it read 0 again.
- R6: A fetch reads index (rp + 1) mod N at byte address base + 4 * index, signalled by a one-cycle request.
- R7: No new request is issued until the command of the previous request has been accepted downstream.
- R8: A presented command keeps valid high and its data stable until ready is seen; on acceptance the read pointer advances by one modulo N, exactly once per accepted command.
- R9: No fetch starts while the read pointer equals the write pointer (register 4, bits [7:0], written value masked to N - 1).
- R10: Fetches start only while the run bit is set; clearing it lets an already requested command complete but starts no further fetch.
- R11: The read pointer and fetch index wrap from N - 1 to 0 for every selected size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index for writes and reads |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Contents of the register selected by regAddr |
| memReq | output | 1 | One-cycle memory read request |
| memAddr | output | 64 | Byte address of the requested entry |
| memRspValid | input | 1 | Memory response strobe |
| memRspData | input | 32 | Memory response data |
| cmdValid | output | 1 | Command word presented downstream |
| cmdReady | input | 1 | Downstream accepts the command |
| cmdData | output | 32 | Command word |

## Verification
The assertions watch, every cycle, that a request never overlaps an unfinished command, that requests only start with the run bit set, the reset bit clear and the pointers unequal, that a stalled command holds its data, that the read pointer sits at 0 during the reset phase and that the aligned base bits read 0. Which index is fetched, the exact address arithmetic, the wrap at each ring size, the refused size and base writes and the stop behaviour with a fetch in flight are only shown by the bench's reference model and its scenarios, under varying memory latency and downstream back-pressure.

// File: rtl/cre_pkg.sv
package cre_pkg;
  localparam int PTR_W      = 8;
  localparam int WORD_W     = 32;
  localparam int MADDR_W    = 64;
  localparam int REG_A_W    = 3;
  localparam int ALIGN_BITS = 7;
  localparam int RST_BIT    = 15;

  localparam logic [REG_A_W-1:0] RA_SIZE    = 3'd0;
  localparam logic [REG_A_W-1:0] RA_BASE_LO = 3'd1;
  localparam logic [REG_A_W-1:0] RA_BASE_HI = 3'd2;
  localparam logic [REG_A_W-1:0] RA_RDPTR   = 3'd3;
  localparam logic [REG_A_W-1:0] RA_WRPTR   = 3'd4;
  localparam logic [REG_A_W-1:0] RA_CTRL    = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} fetchState_t;

  typedef struct packed {
    logic issueFetch;
    logic captureRsp;
    logic advanceRp;
  } ctrlStrobe_t;

  // Index mask for a size-select encoding
  function automatic logic [PTR_W-1:0] sizeMask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'h01;
      2'd1:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cre_ctrl.sv
module cre_ctrl
  import cre_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        canFetch,
  input  logic        memRspValid,
  input  logic        cmdReady,
  output ctrlStrobe_t strobe,
  output logic        cmdValid
);
  fetchState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE: begin
        strobe.issueFetch = canFetch;
        if (canFetch) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        strobe.captureRsp = memRspValid;
        if (memRspValid) stateD = ST_SEND;
      end
      ST_SEND: begin
        strobe.advanceRp = cmdReady;
        if (cmdReady) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign cmdValid = (stateQ == ST_SEND);
endmodule

// File: rtl/cre_dpath.sv
module cre_dpath
  import cre_pkg::*;
#(
  parameter logic [2:0] SIZE_CAP = 3'b111,
  parameter bit         HAS_64   = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_A_W-1:0] regAddr,
  input  logic [WORD_W-1:0]  regWrData,
  output logic [WORD_W-1:0]  regRdData,
  input  ctrlStrobe_t        strobe,
  input  logic [WORD_W-1:0]  memRspData,
  output logic [MADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0]  cmdData,
  output logic               canFetch,
  output logic               runBit,
  output logic               rstBit,
  output logic [PTR_W-1:0]   rdPtr,
  output logic [PTR_W-1:0]   wrPtr
);
  localparam logic [3:0] CAP_PAD = {1'b0, SIZE_CAP};
  localparam int IDX_PAD = MADDR_W - PTR_W - 2;

  logic [1:0]                   selQ;
  logic [WORD_W-1:ALIGN_BITS]   baseLoQ;
  logic [WORD_W-1:0]            baseHi;
  logic [PTR_W-1:0]             rpQ, wpQ, mask, nextIdx;
  logic [WORD_W-1:0]            cmdQ;
  logic                         runQ, rstQ;
  logic                         wrSize, wrBaseLo, wrBaseHi, wrRdPtr, wrWrPtr, wrCtrl;
  logic                         selOk, rstReq;

  assign wrSize   = regWrEn && (regAddr == RA_SIZE);
  assign wrBaseLo = regWrEn && (regAddr == RA_BASE_LO);
  assign wrBaseHi = regWrEn && (regAddr == RA_BASE_HI);
  assign wrRdPtr  = regWrEn && (regAddr == RA_RDPTR);
  assign wrWrPtr  = regWrEn && (regAddr == RA_WRPTR);
  assign wrCtrl   = regWrEn && (regAddr == RA_CTRL);

  assign mask    = sizeMask(selQ);
  assign nextIdx = (rpQ + 1'b1) & mask;
  assign selOk   = CAP_PAD[regWrData[1:0]];
  assign rstReq  = wrRdPtr && regWrData[RST_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ    <= 2'd0;
      baseLoQ <= '0;
      runQ    <= 1'b0;
      rstQ    <= 1'b0;
      wpQ     <= '0;
    end else begin
      if (wrSize && !runQ && selOk) selQ <= regWrData[1:0];
      if (wrBaseLo && !runQ)        baseLoQ <= regWrData[WORD_W-1:ALIGN_BITS];
      if (wrRdPtr)                  rstQ <= regWrData[RST_BIT];
      if (wrWrPtr)                  wpQ <= regWrData[PTR_W-1:0] & mask;
      if (wrCtrl)                   runQ <= regWrData[0];
    end
  end

  // Read pointer: the reset phase holds it at zero and wins over advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rpQ <= '0;
    else if (rstReq || rstQ)   rpQ <= '0;
    else if (strobe.advanceRp) rpQ <= nextIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cmdQ <= '0;
    else if (strobe.captureRsp) cmdQ <= memRspData;
  end

  generate
    if (HAS_64) begin : g_hi
      logic [WORD_W-1:0] hiQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 hiQ <= '0;
        else if (wrBaseHi && !runQ) hiQ <= regWrData;
      end
      assign baseHi = hiQ;
    end else begin : g_lo_only
      logic unusedHiWr;
      assign unusedHiWr = wrBaseHi;
      assign baseHi = '0;
    end
  endgenerate

  assign memAddr  = {baseHi, baseLoQ, {ALIGN_BITS{1'b0}}}
                  + {{IDX_PAD{1'b0}}, nextIdx, 2'b00};
  assign canFetch = runQ && !rstQ && (rpQ != wpQ);
  assign cmdData  = cmdQ;
  assign runBit   = runQ;
  assign rstBit   = rstQ;
  assign rdPtr    = rpQ;
  assign wrPtr    = wpQ;

  always_comb begin
    case (regAddr)
      RA_SIZE:    regRdData = {24'b0, 1'b0, SIZE_CAP, 2'b00, selQ};
      RA_BASE_LO: regRdData = {baseLoQ, {ALIGN_BITS{1'b0}}};
      RA_BASE_HI: regRdData = baseHi;
      RA_RDPTR:   regRdData = {16'b0, rstQ, 7'b0, rpQ};
      RA_WRPTR:   regRdData = {24'b0, wpQ};
      RA_CTRL:    regRdData = {31'b0, runQ};
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
  import cre_pkg::*;
#(
  parameter logic [2:0] SIZE_CAP = 3'b111,
  parameter bit         HAS_64   = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        memReq,
  output logic [63:0] memAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        cmdValid,
  input  logic        cmdReady,
  output logic [31:0] cmdData
);
  ctrlStrobe_t      strobe;
  logic             canFetch;
  logic             runBit, rstBit;
  logic [PTR_W-1:0] rdPtr, wrPtr;

  cre_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .canFetch    (canFetch),
    .memRspValid (memRspValid),
    .cmdReady    (cmdReady),
    .strobe      (strobe),
    .cmdValid    (cmdValid)
  );

  cre_dpath #(.SIZE_CAP(SIZE_CAP), .HAS_64(HAS_64)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .strobe     (strobe),
    .memRspData (memRspData),
    .memAddr    (memAddr),
    .cmdData    (cmdData),
    .canFetch   (canFetch),
    .runBit     (runBit),
    .rstBit     (rstBit),
    .rdPtr      (rdPtr),
    .wrPtr      (wrPtr)
  );

  assign memReq = strobe.issueFetch;
endmodule

// File: rtl/cre_chk.sv
module cre_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic [63:0] memAddr,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic [31:0] cmdData,
  input logic        runBit,
  input logic        rstBit,
  input logic [7:0]  rdPtr,
  input logic [7:0]  wrPtr,
  input logic [2:0]  regAddr,
  input logic [31:0] regRdData
);
  logic busyQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     busyQ <= 1'b0;
    else if (memReq)               busyQ <= 1'b1;
    else if (cmdValid && cmdReady) busyQ <= 1'b0;
  end

  // R7
  single_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !busyQ);
  // R6
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00));
  // R9
  empty_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (rdPtr != wrPtr));
  // R10
  run_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> runBit);
  // R5
  rst_phase_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !rstBit);
  // R5
  rst_phase_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstBit |-> (rdPtr == 8'd0));
  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdData)));
  // R4
  base_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd1) |-> (regRdData[6:0] == 7'd0));
endmodule

bind cmd_ring_engine cre_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memAddr   (memAddr),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .cmdData   (cmdData),
  .runBit    (runBit),
  .rstBit    (rstBit),
  .rdPtr     (rdPtr),
  .wrPtr     (wrPtr),
  .regAddr   (regAddr),
  .regRdData (regRdData)
);

// File: tb/cmd_ring_engine_bench.sv
module cmd_ring_engine_bench;
  localparam logic [2:0] CAP = 3'b011;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        memReq;
  logic [63:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = 32'd0;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [31:0] cmdData;

  int checks = 0, errors = 0, cycle = 0, readyMode = 0, accepted = 0;

  always #5 clk = ~clk;

  cmd_ring_engine #(.SIZE_CAP(CAP), .HAS_64(1'b1)) u_cmd_ring_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memAddr(memAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdData(cmdData)
  );

  // Behavioural reference model
  int          mSel = 0, mRp = 0, mWp = 0, mSt = 0, pendCnt = 0, reqCount = 0;
  bit          mRun = 0, mRst = 0;
  logic [31:0] mBaseLo = 0, mBaseHi = 0, mCmd = 0, pendData = 0;
  bit          tReq, tAdv, tRstW, tOldRun, tOldRst;
  int          tOldSel;
  logic [63:0] tAddr;

  function automatic int nEnt(int s);
    return (s == 0) ? 2 : ((s == 1) ? 16 : 256);
  endfunction
  function automatic bit expReq();
    return (mSt == 0) && mRun && !mRst && (mRp != mWp);
  endfunction
  function automatic logic [63:0] expAddr();
    int idx;
    idx = (mRp + 1) % nEnt(mSel);
    return {mBaseHi, mBaseLo} + 64'(idx * 4);
  endfunction
  function automatic logic [31:0] expRd(logic [2:0] a);
    case (a)
      3'd0: return {24'd0, 1'b0, CAP, 2'b00, 2'(mSel)};
      3'd1: return mBaseLo;
      3'd2: return mBaseHi;
      3'd3: return {16'd0, mRst, 7'd0, 8'(mRp)};
      3'd4: return 32'(mWp);
      3'd5: return {31'd0, mRun};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycle++;
    if (!rstN) begin
      mSel = 0; mRp = 0; mWp = 0; mSt = 0; mRun = 0; mRst = 0;
      mBaseLo = 0; mBaseHi = 0; mCmd = 0; pendCnt = 0;
    end else begin
      if (cmdValid && cmdReady) accepted++;
      tReq = expReq(); tAddr = expAddr();
      tAdv = (mSt == 2) && cmdReady;
      tRstW = regWrEn && regAddr == 3'd3 && regWrData[15];
      tOldRun = mRun; tOldRst = mRst; tOldSel = mSel;
      if (tReq) begin
        pendCnt = 1 + (reqCount % 3);
        pendData = tAddr[31:0] ^ 32'h5A00_0000 ^ 32'(reqCount);
        reqCount++;
      end else if (pendCnt > 0) pendCnt--;
      case (mSt)
        0: if (tReq) mSt = 1;
        1: if (memRspValid) begin mSt = 2; mCmd = memRspData; end
        default: if (cmdReady) mSt = 0;
      endcase
      if (tRstW || tOldRst) mRp = 0;
      else if (tAdv) mRp = (mRp + 1) % nEnt(tOldSel);
      if (regWrEn) begin
        case (regAddr)
          3'd0: if (!tOldRun && regWrData[1:0] != 2'd3 && CAP[regWrData[1:0]]) mSel = int'(regWrData[1:0]);
          3'd1: if (!tOldRun) mBaseLo = {regWrData[31:7], 7'd0};
          3'd2: if (!tOldRun) mBaseHi = regWrData;
          3'd3: mRst = regWrData[15];
          3'd4: mWp = int'(regWrData[7:0]) % nEnt(tOldSel);
          3'd5: mRun = regWrData[0];
          default: ;
        endcase
      end
    end
    if (cycle > 150000) begin
      errors++;
      $display("FAIL watchdog (all requirements) act=%0d exp<150000", cycle);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Memory and downstream drivers
  always @(negedge clk) begin
    memRspValid <= (pendCnt == 1);
    memRspData  <= (pendCnt == 1) ? pendData : 32'hDEAD_BEEF;
    case (readyMode)
      0: cmdReady <= 1'b1;
      1: cmdReady <= (cycle % 3) != 0;
      default: cmdReady <= (cycle % 4) == 3;
    endcase
  end

  // Per-cycle comparison
  always @(negedge clk) begin
    #4;
    if (rstN) begin
      chk("R6 R7 fetch request", {63'd0, memReq}, {63'd0, expReq()});
      if (expReq()) chk("R6 fetch address", memAddr, expAddr());
      chk("R8 command valid", {63'd0, cmdValid}, {63'd0, mSt == 2});
      if (mSt == 2) chk("R8 command data", {32'd0, cmdData}, {32'd0, mCmd});
      chk("R1 register read", {32'd0, regRdData}, {32'd0, expRd(regAddr)});
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask
  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); regAddr = a; #2;
    chk(tag, {32'd0, regRdData}, {32'd0, exp});
  endtask
  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (mSt == 0 && !expReq()) break;
    end
  endtask

  initial begin
    int acc0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rd(3'd0, 32'h30, "R1 size register after reset");
    rd(3'd3, 32'h0, "R5 read pointer after reset");
    chk("R9 no request after reset", {63'd0, memReq}, 64'd0);
    chk("R8 no command after reset", {63'd0, cmdValid}, 64'd0);

    wr(3'd0, 32'd1); rd(3'd0, 32'h31, "R1 select 16 entries");
    wr(3'd0, 32'd2); rd(3'd0, 32'h31, "R2 unsupported 256 ignored");
    wr(3'd0, 32'd3); rd(3'd0, 32'h31, "R2 reserved encoding ignored");

    wr(3'd1, 32'h1234_5FFF); rd(3'd1, 32'h1234_5F80, "R4 base low aligned");
    wr(3'd2, 32'h9);         rd(3'd2, 32'h9, "R4 base high word");

    wr(3'd3, 32'h8000); rd(3'd3, 32'h8000, "R5 reset bit reads 1");
    wr(3'd3, 32'h0);    rd(3'd3, 32'h0, "R5 reset bit reads 0");

    readyMode = 1;
    wr(3'd4, 32'd3); wr(3'd5, 32'd1);
    #3 chk("R6 first fetch at index 1", memAddr, 64'h0000_0009_1234_5F84);
    drain();
    rd(3'd3, 32'd3, "R9 stops when pointers meet");
    chk("R9 idle when empty", {63'd0, memReq}, 64'd0);

    wr(3'd0, 32'd0); rd(3'd0, 32'h31, "R3 size write ignored while running");
    wr(3'd1, 32'd0); rd(3'd1, 32'h1234_5F80, "R3 base write ignored while running");

    readyMode = 2; acc0 = accepted;
    wr(3'd4, 32'd1); drain();
    rd(3'd3, 32'd1, "R11 wrap through 15 to 1");
    chk("R8 one advance per accepted command", 64'(accepted - acc0), 64'd14);

    readyMode = 0;
    wr(3'd4, 32'd5); wr(3'd5, 32'd0); drain();
    rd(3'd3, 32'd2, "R10 in-flight fetch completes after stop");
    repeat (4) begin
      @(negedge clk); #3 chk("R10 no fetch while stopped", {63'd0, memReq}, 64'd0);
    end

    wr(3'd3, 32'h8000); wr(3'd5, 32'd1);
    repeat (4) begin
      @(negedge clk); #3 chk("R5 no fetch during pointer reset", {63'd0, memReq}, 64'd0);
    end
    rd(3'd3, 32'h8000, "R5 pointer held at 0");
    wr(3'd3, 32'h0); drain();
    rd(3'd3, 32'd5, "R5 fetch resumes after reset phase");
    wr(3'd5, 32'd0);

    wr(3'd0, 32'd0); rd(3'd0, 32'h30, "R1 select 2 entries");
    wr(3'd3, 32'h8000); wr(3'd3, 32'h0);
    wr(3'd4, 32'd1); wr(3'd5, 32'd1); drain();
    rd(3'd3, 32'd1, "R11 size 2 first entry");
    wr(3'd4, 32'd0);
    #3 chk("R11 index wraps to 0", memAddr, 64'h0000_0009_1234_5F80);
    drain();
    rd(3'd3, 32'd0, "R11 pointer wraps to 0");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule